// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two processor request outputs, one critical and one non-critical. Every line has its own programmable sensitivity (level or edge), active polarity (high or low) and routing (critical or non-critical). The block holds a raw status word, an enable word and a masked status view. Edge-captured requests stay pending until software acknowledges them by writing a one to the matching status bit.

Inputs that come from outside the clock domain pass through a two-flop synchronizer before any detection. A per-line parameter selects which lines get the synchronizer. A simple register port with a write strobe, a 3-bit address and a combinational read path holds the configuration. Two copies can be chained: the non-critical output of the second copy drives one source line of the first, so the pair serves a larger set of sources.

Register addresses: 0 raw status (write one to clear edge bits), 1 enable, 2 masked status (read only), 3 polarity (1 = active high), 4 sensitivity (1 = edge), 5 routing (1 = critical). All other addresses read as zero.

Top module: `irqc_top`

## Requirements
- R1: After reset, both outputs are 0, status, enable, sensitivity and routing read 0, and polarity reads all ones.
- R2: A level-mode line's status bit equals its polarity-adjusted input: 1 when the input equals its polarity bit.
- R3: Writing ones to address 0 does not clear a level-mode status bit while its input stays active.
- R4: An edge-mode line sets its status bit on the active edge, and the bit stays set after the input returns to inactive.
- R5: A write to address 0 clears each edge-mode status bit whose data bit is 1, and leaves bits written with 0 unchanged.
- R6: With polarity bit 0, a line is active low: level mode reports a low input, and edge mode captures a falling edge.
- R7: Address 2 reads raw status AND enable; writes to address 2 change no register.
- R8: critIrq is the OR of masked bits with routing 1, and normIrq is the OR of masked bits with routing 0, each one clock after status.
- R9: A change of polarity or sensitivity alone does not set an edge-mode status bit.
- R10: A synchronized input change reaches status on the third rising clock edge after it is applied, and reaches the output on the fourth.
- R11: When the non-critical output of a second instance drives source 0, a request on the second instance shows up as an active level on source 0 of the first instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | NUM_SRC | Write data |
| regRdata | output | NUM_SRC | Combinational read data for regAddr |
| irqIn | input | NUM_SRC | Raw interrupt source lines |
| critIrq | output | 1 | Critical request output |
| normIrq | output | 1 | Non-critical request output |

## Verification
A vector table drives six level-mode patterns that change input values, polarity, enable and routing together. These patterns separate a correct polarity match from an inverted one, show the mask acting on the masked view and on the outputs, and show that a single routed bit picks the correct output. Directed sequences then raise and drop edge-mode lines to tell sticky capture apart from level following. They acknowledge with zero and non-zero data, and flip polarity and sensitivity with no input movement, which separates a real edge from a configuration artifact. A cycle-by-cycle probe shows that the synchronizer depth is exactly two. A chained second instance carries a request into source 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS   = 3'd0,
    SEL_ENABLE   = 3'd1,
    SEL_MASKED   = 3'd2,
    SEL_POLARITY = 3'd3,
    SEL_TRIGGER  = 3'd4,
    SEL_CRITICAL = 3'd5
  } regSel_e;

  typedef struct packed {
    logic clrStatus;
    logic ldEnable;
    logic ldPolarity;
    logic ldTrigger;
    logic ldCritical;
  } cfgStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_SRC-1:0]   statusQ,
  input  logic [NUM_SRC-1:0]   enableQ,
  input  logic [NUM_SRC-1:0]   maskedV,
  input  logic [NUM_SRC-1:0]   polQ,
  input  logic [NUM_SRC-1:0]   trigQ,
  input  logic [NUM_SRC-1:0]   critQ,
  output cfgStrobe_t           strobe,
  output logic [NUM_SRC-1:0]   regRdata
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strobe = '0;
    if (regWe) begin
      unique case (sel)
        SEL_STATUS:   strobe.clrStatus  = 1'b1;
        SEL_ENABLE:   strobe.ldEnable   = 1'b1;
        SEL_POLARITY: strobe.ldPolarity = 1'b1;
        SEL_TRIGGER:  strobe.ldTrigger  = 1'b1;
        SEL_CRITICAL: strobe.ldCritical = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_STATUS:   regRdata = statusQ;
      SEL_ENABLE:   regRdata = enableQ;
      SEL_MASKED:   regRdata = maskedV;
      SEL_POLARITY: regRdata = polQ;
      SEL_TRIGGER:  regRdata = trigQ;
      SEL_CRITICAL: regRdata = critQ;
      default:      regRdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] SYNC_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqIn,
  input  cfgStrobe_t           strobe,
  input  logic [NUM_SRC-1:0]   wdata,
  output logic [NUM_SRC-1:0]   statusQ,
  output logic [NUM_SRC-1:0]   enableQ,
  output logic [NUM_SRC-1:0]   polQ,
  output logic [NUM_SRC-1:0]   trigQ,
  output logic [NUM_SRC-1:0]   critQ,
  output logic [NUM_SRC-1:0]   maskedV,
  output logic                 critIrq,
  output logic                 normIrq
);
  logic [NUM_SRC-1:0] syncV;
  logic [NUM_SRC-1:0] prevSync;
  logic [NUM_SRC-1:0] actV, edgeV, w1cV, statusNext;

  // per-line input conditioning: synchronizer where the parameter asks for it
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    if (SYNC_MASK[i]) begin : gSync
      logic stage1, stage2;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
        end else begin
          stage1 <= irqIn[i];
          stage2 <= stage1;
        end
      end
      assign syncV[i] = stage2;
    end else begin : gDirect
      assign syncV[i] = irqIn[i];
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      polQ    <= '1;
      trigQ   <= '0;
      critQ   <= '0;
    end else begin
      if (strobe.ldEnable)   enableQ <= wdata;
      if (strobe.ldPolarity) polQ    <= wdata;
      if (strobe.ldTrigger)  trigQ   <= wdata;
      if (strobe.ldCritical) critQ   <= wdata;
    end
  end

  // edges come from the synchronized line itself, so a polarity flip alone
  // never looks like an edge
  assign actV  = ~(syncV ^ polQ);
  assign edgeV = (syncV & ~prevSync & polQ) | (~syncV & prevSync & ~polQ);
  assign w1cV  = strobe.clrStatus ? wdata : '0;

  assign statusNext = (trigQ & ((statusQ & ~w1cV) | edgeV))
                    | (~trigQ & actV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSync <= '0;
      statusQ  <= '0;
    end else begin
      prevSync <= syncV;
      statusQ  <= statusNext;
    end
  end

  assign maskedV = statusQ & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critIrq <= 1'b0;
      normIrq <= 1'b0;
    end else begin
      critIrq <= |(maskedV & critQ);
      normIrq <= |(maskedV & ~critQ);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] SYNC_MASK = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [NUM_SRC-1:0]  regWdata,
  output logic [NUM_SRC-1:0]  regRdata,
  input  logic [NUM_SRC-1:0]  irqIn,
  output logic                critIrq,
  output logic                normIrq
);
  cfgStrobe_t         strobe;
  logic [NUM_SRC-1:0] statusQ, enableQ, polQ, trigQ, critQ, maskedV;

  irqc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .statusQ (statusQ),
    .enableQ (enableQ),
    .maskedV (maskedV),
    .polQ    (polQ),
    .trigQ   (trigQ),
    .critQ   (critQ),
    .strobe  (strobe),
    .regRdata(regRdata)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .SYNC_MASK(SYNC_MASK)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strobe (strobe),
    .wdata  (regWdata),
    .statusQ(statusQ),
    .enableQ(enableQ),
    .polQ   (polQ),
    .trigQ  (trigQ),
    .critQ  (critQ),
    .maskedV(maskedV),
    .critIrq(critIrq),
    .normIrq(normIrq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [2:0]         regAddr,
  input logic [NUM_SRC-1:0] regWdata,
  input logic [NUM_SRC-1:0] regRdata,
  input logic               critIrq,
  input logic               normIrq,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] trigQ,
  input logic [NUM_SRC-1:0] critQ
);
  logic [NUM_SRC-1:0] ackV, keepV;
  assign ackV  = (regWe && regAddr == 3'd0) ? regWdata : '0;
  assign keepV = statusQ & trigQ & ~ackV;

  // R8: critical output follows the routed masked bits one clock later
  assert_crit_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (critIrq == $past(|(statusQ & enableQ & critQ))));

  // R8: non-critical output rises only after a routed masked bit was present
  assert_norm_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(normIrq) |-> $past(|(statusQ & enableQ & ~critQ)));

  // R4 / R5: a pending edge bit not acknowledged stays pending
  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & trigQ & $past(keepV)) == (trigQ & $past(keepV))));

  // R7: masked view read path
  assert_masked_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd2) |-> (regRdata == (statusQ & enableQ)));
endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .critIrq (critIrq),
  .normIrq (normIrq),
  .statusQ (statusQ),
  .enableQ (enableQ),
  .trigQ   (trigQ),
  .critQ   (critQ)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mWe = 1'b0, sWe = 1'b0;
  logic [2:0]  mAddr = '0, sAddr = '0;
  logic [31:0] mWdata = '0, sWdata = '0;
  logic [31:0] mRdata, sRdata;
  logic [31:0] tbIrq = '0, slaveIrq = '0;
  logic [31:0] masterIn;
  logic        mCrit, mNorm, sCrit, sNorm;
  int          nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  assign masterIn = {tbIrq[31:1], sNorm};

  irqc_top u_dut (
    .clk(clk), .rstN(rstN), .regWe(mWe), .regAddr(mAddr), .regWdata(mWdata),
    .regRdata(mRdata), .irqIn(masterIn), .critIrq(mCrit), .normIrq(mNorm)
  );

  irqc_top u_cascade (
    .clk(clk), .rstN(rstN), .regWe(sWe), .regAddr(sAddr), .regWdata(sWdata),
    .regRdata(sRdata), .irqIn(slaveIrq), .critIrq(sCrit), .normIrq(sNorm)
  );

  // entry: {irq, enable, polarity, routing}, all lines level mode
  localparam logic [127:0] VECS [6] = '{
    {32'h0000_00F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_00F0, 32'h0000_000F, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_1000},
    {32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000},
    {32'hFFFF_FFFE, 32'h0000_0001, 32'hFFFF_FFFE, 32'h0000_0000},
    {32'h0000_0000, 32'hFF00_0000, 32'h00FF_FFFF, 32'h0F00_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit toSlave, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    if (toSlave) begin sWe = 1'b1; sAddr = a; sWdata = d; end
    else begin mWe = 1'b1; mAddr = a; mWdata = d; end
    @(negedge clk);
    sWe = 1'b0; mWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    mAddr = a;
    #1 d = mRdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tbIrq = '0; slaveIrq = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] v, inV, actV, expSt, expMask;
    doReset();

    // R1: reset state
    chk("R1 crit", {31'b0, mCrit}, 32'h0);
    chk("R1 norm", {31'b0, mNorm}, 32'h0);
    rd(3'd0, v); chk("R1 status", v, 32'h0);
    rd(3'd1, v); chk("R1 enable", v, 32'h0);
    rd(3'd3, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R1 trigger", v, 32'h0);
    rd(3'd5, v); chk("R1 routing", v, 32'h0);

    // R2 / R6 / R7 / R8: table of level-mode patterns
    for (int k = 0; k < 6; k++) begin
      logic [31:0] irqV, enV, polV, critV;
      {irqV, enV, polV, critV} = VECS[k];
      wr(0, 3'd1, enV);
      wr(0, 3'd3, polV);
      wr(0, 3'd5, critV);
      @(negedge clk); tbIrq = irqV;
      settle();
      inV     = {irqV[31:1], 1'b0};
      actV    = ~(inV ^ polV);
      expSt   = actV;
      expMask = expSt & enV;
      rd(3'd0, v); chk($sformatf("R2/R6 status vec%0d", k), v, expSt);
      rd(3'd2, v); chk($sformatf("R7 masked vec%0d", k), v, expMask);
      chk($sformatf("R8 crit vec%0d", k), {31'b0, mCrit}, {31'b0, |(expMask & critV)});
      chk($sformatf("R8 norm vec%0d", k), {31'b0, mNorm}, {31'b0, |(expMask & ~critV)});
    end

    // R7: writes to the masked view change nothing
    rd(3'd1, expSt);
    wr(0, 3'd2, 32'h1234_5678);
    rd(3'd1, v); chk("R7 enable after masked write", v, expSt);

    doReset();
    wr(0, 3'd1, 32'h0000_02A0);   // enable bits 5, 7, 9

    // R10: synchronizer depth, level mode bit 5
    @(negedge clk); tbIrq[5] = 1'b1;
    @(negedge clk); mAddr = 3'd0; #1 chk("R10 status after 1 edge", mRdata & 32'h20, 32'h0);
    @(negedge clk); #1 chk("R10 status after 2 edges", mRdata & 32'h20, 32'h0);
    @(negedge clk); #1 chk("R10 status after 3 edges", mRdata & 32'h20, 32'h20);
    chk("R10 norm before 4th edge", {31'b0, mNorm}, 32'h0);
    @(negedge clk); chk("R10 norm after 4th edge", {31'b0, mNorm}, 32'h1);

    // R3: acknowledging an active level bit leaves it set
    wr(0, 3'd0, 32'h0000_0020);
    rd(3'd0, v); chk("R3 level bit after ack", v & 32'h20, 32'h20);
    @(negedge clk); tbIrq[5] = 1'b0;
    settle();

    // R4: edge capture on bit 7, active high
    wr(0, 3'd4, 32'h0000_0080);
    @(negedge clk); tbIrq[7] = 1'b1; settle();
    @(negedge clk); tbIrq[7] = 1'b0; settle();
    rd(3'd0, v); chk("R4 edge bit held after input drop", v & 32'h80, 32'h80);
    chk("R4 norm held", {31'b0, mNorm}, 32'h1);

    // R5: ack with zero data does nothing, ack with one clears
    wr(0, 3'd0, 32'h0000_0000);
    rd(3'd0, v); chk("R5 zero ack keeps bit", v & 32'h80, 32'h80);
    wr(0, 3'd0, 32'h0000_0080);
    rd(3'd0, v); chk("R5 one ack clears bit", v & 32'h80, 32'h0);
    settle();
    chk("R5 norm drops", {31'b0, mNorm}, 32'h0);

    // R9 / R6: bit 9 held high, made active low, then edge mode
    @(negedge clk); tbIrq[9] = 1'b1; settle();
    wr(0, 3'd3, 32'hFFFF_FDFF);
    settle();
    rd(3'd0, v); chk("R6 active-low level sees high input inactive", v & 32'h200, 32'h0);
    wr(0, 3'd4, 32'h0000_0280);
    settle();
    rd(3'd0, v); chk("R9 sensitivity change sets nothing", v & 32'h200, 32'h0);
    wr(0, 3'd3, 32'hFFFF_FFFF);
    settle();
    rd(3'd0, v); chk("R9 polarity change sets nothing", v & 32'h200, 32'h0);
    wr(0, 3'd3, 32'hFFFF_FDFF);
    @(negedge clk); tbIrq[9] = 1'b0; settle();
    rd(3'd0, v); chk("R6 falling edge captured", v & 32'h200, 32'h200);

    // R11: request from the chained instance lands on source 0
    doReset();
    wr(0, 3'd1, 32'h0000_0001);
    wr(1, 3'd1, 32'h0000_0008);
    rd(3'd0, v); chk("R11 source 0 idle", v & 32'h1, 32'h0);
    @(negedge clk); slaveIrq[3] = 1'b1;
    repeat (12) @(negedge clk);
    rd(3'd0, v); chk("R11 source 0 active", v & 32'h1, 32'h1);
    chk("R11 master norm", {31'b0, mNorm}, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule